// File: doc/BRIEF.md
# Banked Memory Address Generator

This block turns the logical addresses of a small 4-bit controller core into physical addresses for its program ROM and its data RAM. The program side maps the 13-bit program counter onto a 16K-byte ROM made of four 4K banks. The lower 4K of the counter space always reaches bank 0. A 2-bit bank select register picks which bank appears in the upper 4K. The same side holds a 12-bit table pointer that the core loads one nibble at a time. A table lookup then fetches the ROM byte at that pointer from the currently mapped upper bank and returns either its low or its high nibble. A high-nibble fetch also steps the pointer forward by one.

The data side combines a 4-bit RAM bank code with the H and L pointer nibbles, with an 8-bit direct operand, or with a 4-bit zero-page operand, according to the addressing mode. Bank codes above nine fold back to bank 0. Bank 0 is only partly populated. An access that falls into its unpopulated top part is flagged, reads as zero and never writes. The ROM and RAM arrays and the instruction decoder sit outside this block.

Top module: `bank_addr_gen`

## Requirements
- R1: While no table lookup is requested and pc[12] is 0, romAddr equals {2'b00, pc[11:0]}.
- R2: While no table lookup is requested and pc[12] is 1, romAddr[11:0] equals pc[11:0] and romAddr[13:12] is 1 for bank select 00 or 11, 2 for 01 and 3 for 10.
- R3: After reset the bank select and the table pointer are both 0, so pc 1000h maps to romAddr 1000h and dpOut reads 000h.
- R4: A high on romBankWe loads romBankD into the bank select at the clock edge. A high on dpLoadLo, dpLoadMid or dpLoadHi loads dpNibble into pointer bits [3:0], [7:4] or [11:8] respectively, and any combination may load in the same cycle.
- R5: While tblLo or tblHi is high, romAddr equals {upper-bank code from R2, dpOut}. tblNibble is romData[7:4] when tblHi is high and romData[3:0] otherwise, and tblHi takes precedence over tblLo.
- R6: A cycle with tblHi high and no pointer load increments the pointer by 1, wrapping from FFFh to 000h. A cycle with only tblLo high leaves the pointer unchanged.
- R7: In a cycle where any pointer nibble load is requested, the pointer takes the loaded value and no increment happens, even if tblHi is high.
- R8: The RAM bank code selects bank 0 to 9 for codes 0 to 9, and bank 0 for codes 10 to 15. ramAddr[11:8] carries the selected bank in the indirect and direct modes.
- R9: With ramMode 00 (indirect), ramAddr is {bank, hPtr, lPtr}. With ramMode 01 (direct), it is {bank, dirOp}. With ramMode 10 or 11 (zero page), it is {8'h00, zpOp} whatever the bank code is.
- R10: When the selected bank is 0 and ramAddr[7:0] is F4h or higher, ramInvalid is 1, ramRdOut is 0 and ramWrEn is 0. Otherwise ramInvalid is 0, ramWrEn equals ramWrReq and ramRdOut equals ramRdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pc | input | 13 | Program counter |
| romBankWe | input | 1 | Load strobe for the ROM bank select |
| romBankD | input | 2 | New ROM bank select value |
| dpLoadLo | input | 1 | Load dpNibble into pointer bits [3:0] |
| dpLoadMid | input | 1 | Load dpNibble into pointer bits [7:4] |
| dpLoadHi | input | 1 | Load dpNibble into pointer bits [11:8] |
| dpNibble | input | 4 | Nibble written by the pointer loads |
| tblLo | input | 1 | Low-nibble table lookup request |
| tblHi | input | 1 | High-nibble table lookup request, post-increments pointer |
| romData | input | 8 | Byte returned by the ROM at romAddr |
| ramBank | input | 4 | RAM bank code |
| hPtr | input | 4 | H pointer nibble |
| lPtr | input | 4 | L pointer nibble |
| dirOp | input | 8 | Direct-mode operand |
| zpOp | input | 4 | Zero-page operand |
| ramMode | input | 2 | 00 indirect, 01 direct, 1x zero page |
| ramWrReq | input | 1 | Write request from the core |
| ramRdData | input | 4 | Nibble read from the RAM array |
| romAddr | output | 14 | Physical ROM address |
| tblNibble | output | 4 | Nibble returned by a table lookup |
| dpOut | output | 12 | Current table pointer |
| ramAddr | output | 12 | Physical RAM address |
| ramInvalid | output | 1 | Access falls in unpopulated bank 0 space |
| ramWrEn | output | 1 | Qualified write enable to the RAM array |
| ramRdOut | output | 4 | Qualified read data to the core |

## Verification
A wrong bank select shows up in the same cycle as the wrong romAddr[13:12] for any upper-half fetch or table lookup. A lower-half fetch hides it, so the stimulus moves pc between both halves. A corrupted pointer is visible on dpOut at once and on romAddr for the next lookup. An increment that is missed or doubled shows one cycle after a high-nibble fetch, and a missing load-wins rule shows one cycle after a clash. RAM decode errors are purely combinational. They appear as soon as the bank code, mode or operands change, and the codes 10 to 15 and the F3h/F4h border in bank 0 are driven directly.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;

  localparam int PC_W      = 13;
  localparam int DP_W      = 12;
  localparam int NIB_W     = 4;
  localparam int DP_NIBS   = DP_W / NIB_W;
  localparam int ROM_SEL_W = 2;
  localparam int ROM_A_W   = PC_W + 1;
  localparam int RAM_BK_W  = 4;
  localparam int RAM_A_W   = RAM_BK_W + 8;

  typedef enum logic [1:0] {
    MODE_IND  = 2'b00,
    MODE_DIR  = 2'b01,
    MODE_ZP   = 2'b10,
    MODE_ZP2  = 2'b11
  } ramMode_e;

  typedef struct packed {
    logic [DP_NIBS-1:0] dpLoad;
    logic               dpInc;
    logic               bankWe;
    logic               tblActive;
    logic               tblHigh;
  } addrStrobes_t;

endpackage

// File: rtl/bank_addr_ctrl.sv
module bank_addr_ctrl
  import bank_addr_pkg::*;
(
  input  logic         romBankWe,
  input  logic         dpLoadLo,
  input  logic         dpLoadMid,
  input  logic         dpLoadHi,
  input  logic         tblLo,
  input  logic         tblHi,
  output addrStrobes_t strobes
);

  logic anyLoad;

  always_comb begin
    strobes           = '0;
    strobes.dpLoad    = {dpLoadHi, dpLoadMid, dpLoadLo};
    anyLoad           = |strobes.dpLoad;
    // a pointer load in the same cycle pre-empts the post-increment
    strobes.dpInc     = tblHi & ~anyLoad;
    strobes.bankWe    = romBankWe;
    strobes.tblActive = tblLo | tblHi;
    strobes.tblHigh   = tblHi;
  end

endmodule

// File: rtl/bank_addr_path.sv
module bank_addr_path
  import bank_addr_pkg::*;
#(
  parameter int RAM_BANKS = 10,
  parameter int BANK0_TOP = 8'hF3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  addrStrobes_t         strobes,
  input  logic [PC_W-1:0]      pc,
  input  logic [ROM_SEL_W-1:0] romBankD,
  input  logic [NIB_W-1:0]     dpNibble,
  input  logic [7:0]           romData,
  input  logic [RAM_BK_W-1:0]  ramBank,
  input  logic [NIB_W-1:0]     hPtr,
  input  logic [NIB_W-1:0]     lPtr,
  input  logic [7:0]           dirOp,
  input  logic [NIB_W-1:0]     zpOp,
  input  logic [1:0]           ramMode,
  input  logic                 ramWrReq,
  input  logic [NIB_W-1:0]     ramRdData,
  output logic [ROM_A_W-1:0]   romAddr,
  output logic [NIB_W-1:0]     tblNibble,
  output logic [DP_W-1:0]      dpOut,
  output logic [RAM_A_W-1:0]   ramAddr,
  output logic                 ramInvalid,
  output logic                 ramWrEn,
  output logic [NIB_W-1:0]     ramRdOut
);

  logic [ROM_SEL_W-1:0] romSel;
  logic [DP_W-1:0]      dpReg;
  logic [DP_W-1:0]      dpLoaded;
  logic [DP_W-1:0]      dpNext;
  logic [1:0]           upperBank;
  logic [RAM_BK_W-1:0]  bankEff;

  // nibble-wise pointer loads
  for (genvar g = 0; g < DP_NIBS; g++) begin : gNibLoad
    assign dpLoaded[g*NIB_W +: NIB_W] =
      strobes.dpLoad[g] ? dpNibble : dpReg[g*NIB_W +: NIB_W];
  end

  assign dpNext = strobes.dpInc ? dpReg + 1'b1 : dpLoaded;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romSel <= '0;
      dpReg  <= '0;
    end else begin
      if (strobes.bankWe) romSel <= romBankD;
      dpReg <= dpNext;
    end
  end

  assign dpOut = dpReg;

  // upper-half bank: codes 00 and 11 both reach bank 1
  always_comb begin
    case (romSel)
      2'b01:   upperBank = 2'd2;
      2'b10:   upperBank = 2'd3;
      default: upperBank = 2'd1;
    endcase
  end

  always_comb begin
    if (strobes.tblActive)
      romAddr = {upperBank, dpReg};
    else if (pc[PC_W-1])
      romAddr = {upperBank, pc[PC_W-2:0]};
    else
      romAddr = {2'b00, pc[PC_W-2:0]};
  end

  assign tblNibble = strobes.tblHigh ? romData[7:4] : romData[3:0];

  // RAM side: unused bank codes fold back to bank 0
  assign bankEff = (int'(ramBank) < RAM_BANKS) ? ramBank : '0;

  always_comb begin
    case (ramMode)
      MODE_IND: ramAddr = {bankEff, hPtr, lPtr};
      MODE_DIR: ramAddr = {bankEff, dirOp};
      default:  ramAddr = {{(RAM_A_W-NIB_W){1'b0}}, zpOp};
    endcase
  end

  assign ramInvalid = (ramAddr[RAM_A_W-1:8] == '0) && (int'(ramAddr[7:0]) > BANK0_TOP);
  assign ramWrEn    = ramWrReq & ~ramInvalid;
  assign ramRdOut   = ramInvalid ? '0 : ramRdData;

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bank_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [12:0] pc,
  input  logic        romBankWe,
  input  logic [1:0]  romBankD,
  input  logic        dpLoadLo,
  input  logic        dpLoadMid,
  input  logic        dpLoadHi,
  input  logic [3:0]  dpNibble,
  input  logic        tblLo,
  input  logic        tblHi,
  input  logic [7:0]  romData,
  input  logic [3:0]  ramBank,
  input  logic [3:0]  hPtr,
  input  logic [3:0]  lPtr,
  input  logic [7:0]  dirOp,
  input  logic [3:0]  zpOp,
  input  logic [1:0]  ramMode,
  input  logic        ramWrReq,
  input  logic [3:0]  ramRdData,
  output logic [13:0] romAddr,
  output logic [3:0]  tblNibble,
  output logic [11:0] dpOut,
  output logic [11:0] ramAddr,
  output logic        ramInvalid,
  output logic        ramWrEn,
  output logic [3:0]  ramRdOut
);

  addrStrobes_t strobes;

  bank_addr_ctrl uCtrl (
    .romBankWe (romBankWe),
    .dpLoadLo  (dpLoadLo),
    .dpLoadMid (dpLoadMid),
    .dpLoadHi  (dpLoadHi),
    .tblLo     (tblLo),
    .tblHi     (tblHi),
    .strobes   (strobes)
  );

  bank_addr_path uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pc         (pc),
    .romBankD   (romBankD),
    .dpNibble   (dpNibble),
    .romData    (romData),
    .ramBank    (ramBank),
    .hPtr       (hPtr),
    .lPtr       (lPtr),
    .dirOp      (dirOp),
    .zpOp       (zpOp),
    .ramMode    (ramMode),
    .ramWrReq   (ramWrReq),
    .ramRdData  (ramRdData),
    .romAddr    (romAddr),
    .tblNibble  (tblNibble),
    .dpOut      (dpOut),
    .ramAddr    (ramAddr),
    .ramInvalid (ramInvalid),
    .ramWrEn    (ramWrEn),
    .ramRdOut   (ramRdOut)
  );

endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic [12:0] pc,
  input logic        dpLoadLo,
  input logic        dpLoadMid,
  input logic        dpLoadHi,
  input logic [3:0]  dpNibble,
  input logic        tblLo,
  input logic        tblHi,
  input logic [1:0]  ramMode,
  input logic        ramWrReq,
  input logic [13:0] romAddr,
  input logic [11:0] dpOut,
  input logic [11:0] ramAddr,
  input logic        ramInvalid,
  input logic        ramWrEn,
  input logic [3:0]  ramRdOut
);

  logic anyLd;
  assign anyLd = dpLoadLo | dpLoadMid | dpLoadHi;

  AST_LOWER_HALF_BANK0: assert property (@(posedge clk) disable iff (!rstN)
    (!tblLo && !tblHi && !pc[12]) |-> romAddr == {2'b00, pc[11:0]}); // R1

  AST_UPPER_NEVER_BANK0: assert property (@(posedge clk) disable iff (!rstN)
    (tblLo || tblHi || pc[12]) |-> romAddr[13:12] != 2'b00); // R2

  AST_TBL_USES_POINTER: assert property (@(posedge clk) disable iff (!rstN)
    (tblLo || tblHi) |-> romAddr[11:0] == dpOut); // R5

  AST_HI_FETCH_INC: assert property (@(posedge clk) disable iff (!rstN)
    (tblHi && !anyLd) |=> dpOut == $past(dpOut) + 12'd1); // R6

  AST_LO_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (tblLo && !tblHi && !anyLd) |=> $stable(dpOut)); // R6

  AST_LOAD_BEATS_INC: assert property (@(posedge clk) disable iff (!rstN)
    (dpLoadLo && tblHi) |=> dpOut[3:0] == $past(dpNibble)); // R7

  AST_ZERO_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramMode[1] |-> ramAddr[11:4] == 8'h00); // R9

  AST_INVALID_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    ramInvalid |-> (!ramWrEn && ramRdOut == 4'h0)); // R10

  AST_VALID_PASSES_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!ramInvalid && ramWrReq) |-> ramWrEn); // R10

endmodule

bind bank_addr_gen bank_addr_gen_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .pc         (pc),
  .dpLoadLo   (dpLoadLo),
  .dpLoadMid  (dpLoadMid),
  .dpLoadHi   (dpLoadHi),
  .dpNibble   (dpNibble),
  .tblLo      (tblLo),
  .tblHi      (tblHi),
  .ramMode    (ramMode),
  .ramWrReq   (ramWrReq),
  .romAddr    (romAddr),
  .dpOut      (dpOut),
  .ramAddr    (ramAddr),
  .ramInvalid (ramInvalid),
  .ramWrEn    (ramWrEn),
  .ramRdOut   (ramRdOut)
);

// File: tb/bank_addr_gen_test.sv
module bank_addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [12:0] pc;
  logic        romBankWe;
  logic [1:0]  romBankD;
  logic        dpLoadLo, dpLoadMid, dpLoadHi;
  logic [3:0]  dpNibble;
  logic        tblLo, tblHi;
  logic [7:0]  romData;
  logic [3:0]  ramBank, hPtr, lPtr, zpOp, ramRdData;
  logic [7:0]  dirOp;
  logic [1:0]  ramMode;
  logic        ramWrReq;
  logic [13:0] romAddr;
  logic [3:0]  tblNibble;
  logic [11:0] dpOut;
  logic [11:0] ramAddr;
  logic        ramInvalid, ramWrEn;
  logic [3:0]  ramRdOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [1:0]  mSel;
  logic [11:0] mDp;

  always #10 clk = ~clk;

  bank_addr_gen uut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] upBank(logic [1:0] s);
    case (s)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [11:0] expRam(logic [3:0] bk, logic [1:0] md,
      logic [3:0] h, logic [3:0] l, logic [7:0] d, logic [3:0] z);
    logic [3:0] b;
    b = (bk > 4'd9) ? 4'd0 : bk;
    if (md == 2'b00) return {b, h, l};
    if (md == 2'b01) return {b, d};
    return {8'h00, z};
  endfunction

  // check all outputs against the model, then advance one clock
  task automatic stepCheck();
    logic [13:0] eRom;
    logic [11:0] eRam;
    logic        eInv;
    string       romTag;
    #1;
    if (tblLo || tblHi) begin eRom = {upBank(mSel), mDp}; romTag = "R5"; end
    else if (pc[12])    begin eRom = {upBank(mSel), pc[11:0]}; romTag = "R2"; end
    else                begin eRom = {2'b00, pc[11:0]}; romTag = "R1"; end
    check(romTag, 16'(romAddr), 16'(eRom));
    if (tblLo || tblHi)
      check("R5 nibble", 16'(tblNibble), 16'(tblHi ? romData[7:4] : romData[3:0]));
    check("R6 pointer", 16'(dpOut), 16'(mDp));
    eRam = expRam(ramBank, ramMode, hPtr, lPtr, dirOp, zpOp);
    check(ramMode[1] ? "R9 zp" : "R8 R9 addr", 16'(ramAddr), 16'(eRam));
    eInv = (eRam[11:8] == 4'd0) && (eRam[7:0] > 8'hF3);
    check("R10 invalid", 16'(ramInvalid), 16'(eInv));
    check("R10 wren", 16'(ramWrEn), 16'(ramWrReq & ~eInv));
    check("R10 rdata", 16'(ramRdOut), 16'(eInv ? 4'h0 : ramRdData));
    @(posedge clk);
    if (romBankWe) mSel = romBankD;
    if (dpLoadLo || dpLoadMid || dpLoadHi) begin
      if (dpLoadLo)  mDp[3:0]  = dpNibble;
      if (dpLoadMid) mDp[7:4]  = dpNibble;
      if (dpLoadHi)  mDp[11:8] = dpNibble;
    end else if (tblHi) mDp = mDp + 12'd1;
    @(negedge clk);
  endtask

  task automatic idle();
    romBankWe = 0; dpLoadLo = 0; dpLoadMid = 0; dpLoadHi = 0;
    tblLo = 0; tblHi = 0; ramWrReq = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0427));
    rstN = 0; idle();
    pc = 13'h1000; romBankD = 2'b10; dpNibble = 4'hF; romData = 8'hA5;
    ramBank = 0; hPtr = 0; lPtr = 0; dirOp = 0; zpOp = 0; ramMode = 0; ramRdData = 4'h6;
    mSel = 0; mDp = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R3 reset pointer", 16'(dpOut), 16'h000);
    check("R3 reset bank", 16'(romAddr), 16'h1000);
    rstN = 1;
    @(negedge clk);

    // R4 bank select codes, R2 upper mapping for each
    for (int s = 0; s < 4; s++) begin
      romBankD = 2'(s); romBankWe = 1; stepCheck(); idle();
      pc = 13'h1ABC; stepCheck();
      pc = 13'h0ABC; stepCheck();
    end

    // R4 nibble loads, then R6 wrap of high fetches from FFF
    dpNibble = 4'hF; dpLoadLo = 1; dpLoadMid = 1; dpLoadHi = 1; stepCheck(); idle();
    check("R4 full load", 16'(dpOut), 16'hFFF);
    tblHi = 1; romData = 8'h3C; stepCheck(); idle();
    check("R6 wrap", 16'(dpOut), 16'h000);
    tblLo = 1; stepCheck(); idle();
    check("R6 lo hold", 16'(dpOut), 16'h000);

    // R7 load wins over increment
    dpNibble = 4'h7; dpLoadMid = 1; tblHi = 1; stepCheck(); idle();
    check("R7 load wins", 16'(dpOut), 16'h070);

    // R8 folded bank codes and R10 border in bank 0
    for (int b = 9; b < 16; b++) begin
      ramBank = 4'(b); ramMode = 2'b01; dirOp = 8'hF3; ramWrReq = 1; stepCheck();
      dirOp = 8'hF4; ramWrReq = 1; stepCheck();
      ramMode = 2'b00; hPtr = 4'hF; lPtr = 4'hF; ramWrReq = 1; stepCheck();
    end
    ramBank = 4'h5; ramMode = 2'b10; zpOp = 4'hC; stepCheck();
    check("R9 zp ignores bank", 16'(ramAddr), 16'h00C);
    idle();

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      pc        = 13'($urandom);
      romBankWe = ($urandom % 6) == 0;
      romBankD  = 2'($urandom);
      dpLoadLo  = ($urandom % 8) == 0;
      dpLoadMid = ($urandom % 8) == 0;
      dpLoadHi  = ($urandom % 8) == 0;
      dpNibble  = 4'($urandom);
      tblLo     = ($urandom % 4) == 0;
      tblHi     = ($urandom % 3) == 0;
      romData   = 8'($urandom);
      ramBank   = 4'($urandom);
      hPtr      = 4'($urandom);
      lPtr      = 4'($urandom);
      dirOp     = ($urandom % 4 == 0) ? 8'(8'hF0 + $urandom % 16) : 8'($urandom);
      zpOp      = 4'($urandom);
      ramMode   = 2'($urandom);
      ramWrReq  = 1'($urandom);
      ramRdData = 4'($urandom);
      stepCheck();
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule